// File: doc/BRIEF.md
# Pulse Position Downlink Decoder

This block turns reader-to-tag command frames into bytes. The frames use pulse position modulation. It runs on a clock at the carrier rate. Its one data input is a synchronised, active-high level that is high while the analog front end sees a carrier pause. Only the leading edge of each pause carries timing. The pause width does not matter, as long as it ends before the next pause is due.

Each frame opens with two pauses. The distance between them selects the coding mode:

- In quad mode, one pause among four slots of `SLOT_CYC` carrier cycles carries two bits, and four such symbols make a byte.
- In wide mode, one pause among 256 slots carries a whole byte.

A pause that arrives one and a half slots after the previous pause closes the frame. Any pause that is misplaced, duplicated or missing aborts the frame and raises a one-cycle error strobe. The decoder then waits for a new opening pair.

Top module: `ppmDownlinkDecoder`

## Requirements
- R1: During reset and in the first cycle after it, every strobe, the mode flag and the data byte are low.
- R2: When the leading edges of two pauses are 4*SLOT_CYC (±SLOT_CYC/16) cycles apart, the decoder raises frameStart for one cycle and sets modeQuad to 1. The symbol grid begins SLOT_CYC/2 cycles after the second of these edges.
- R3: When the leading edges of two pauses are 3*SLOT_CYC (±SLOT_CYC/16) cycles apart, the decoder raises frameStart for one cycle and sets modeQuad to 0. The symbol grid starts in the same way as in R2.
- R4: In quad mode a symbol is 4 slots long. A pause edge at offset SLOT_CYC/2 inside slot k (k = 0..3) yields the bit pair k. The first symbol of a byte supplies bits [1:0] and the fourth supplies bits [7:6]. byteValid pulses once per four symbols.
- R5: In wide mode a symbol is 256 slots long. A pause at mid-slot k yields the byte k, so slot 0 gives 00h and slot 255 gives FFh. byteValid pulses once per symbol.
- R6: A pause edge 3*SLOT_CYC/2 (±SLOT_CYC/16) cycles after the previous pause edge, with no partial byte pending, raises frameEnd for one cycle and ends the frame.
- R7: A symbol that ends without a pause raises frameErr and aborts the frame.
- R8: A second pause inside the same symbol raises frameErr and aborts the frame.
- R9: A data pause whose edge lies more than SLOT_CYC/16 cycles from the middle of its slot raises frameErr and aborts the frame.
- R10: An end pause that arrives while one to three bit pairs of a quad-mode byte are pending raises frameErr instead of frameEnd.
- R11: An opening pair whose spacing matches neither mode produces no event. Its second pause becomes the first pause of a new opening pair.
- R12: A data pause up to SLOT_CYC/16 cycles early or late decodes the same as a pause at exact mid-slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pauseIn | input | 1 | Synchronised pause level, high during a carrier pause |
| dataByte | output | 8 | Last decoded byte, valid with byteValid |
| byteValid | output | 1 | One-cycle strobe for a new byte |
| frameStart | output | 1 | One-cycle strobe when an opening pair is recognised |
| frameEnd | output | 1 | One-cycle strobe when a frame closes cleanly |
| frameErr | output | 1 | One-cycle strobe when a frame is aborted |
| modeQuad | output | 1 | 1 for the four-slot mode, 0 for the 256-slot mode |

## Verification
In quad mode, the byte E1h and two other values check the pair order and every slot position. A jittered byte, with pauses alternately early and late by the full tolerance, shows that the acceptance window is as wide as required. In wide mode, 00h and FFh probe the two outermost slots. A mid-range value confirms that the slot index maps directly to the byte.

Four aborted frames tell the error causes apart: a missing pause, a doubled pause, an off-grid pause and an end pause during a partial byte. An opening pair with a non-matching spacing, followed at once by a valid pair, shows that the decoder discards the bad pair silently and resynchronises on the later pause.

// File: rtl/ppmPkg.sv
package ppmPkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SOF, ST_DATA} ppmStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic clrGap;     // restart pause-to-pause distance counter
    logic armSym;     // start the lead-in before the first symbol
    logic takePause;  // accept a data pause at the current slot
    logic clrByte;    // drop any partial bit pairs
  } dpCtrlT;
endpackage

// File: rtl/ppmData.sv
module ppmData import ppmPkg::*; #(
  parameter  int SLOT_CYC = 256,
  localparam int SL_W     = $clog2(SLOT_CYC),
  localparam int HALF     = SLOT_CYC / 2,
  localparam int QUAD_LEN = 4 * SLOT_CYC,
  localparam int FULL_LEN = 256 * SLOT_CYC,
  localparam int PH_W     = SL_W + 8,
  localparam int GAP_W    = $clog2(QUAD_LEN) + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pauseIn,
  input  logic             modeQuad,
  input  dpCtrlT           ctl,
  output logic             pauseEdge,
  output logic [GAP_W-1:0] gap,
  output logic [SL_W-1:0]  slotOff,
  output logic             inSym,
  output logic             symEnd,
  output logic             pairBusy,
  output logic [7:0]       dataByte,
  output logic             byteValid
);
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  logic            pausePrev;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] symLast;
  logic            lead;
  logic [7:0]      slotIdx;
  logic [5:0]      pairAcc;
  logic [1:0]      pairCnt;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) pausePrev <= 1'b0;
    else       pausePrev <= pauseIn;

  assign pauseEdge = pauseIn & ~pausePrev;

  // distance since the last accepted pause edge, saturating
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              gap <= GAP_MAX;
    else if (ctl.clrGap)    gap <= GAP_W'(1);
    else if (gap != GAP_MAX) gap <= gap + 1'b1;

  assign symLast = modeQuad ? PH_W'(QUAD_LEN - 1) : PH_W'(FULL_LEN - 1);

  // symbol phase; lead covers the half slot between opening pause and grid
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      phase <= '0;
      lead  <= 1'b1;
    end else if (ctl.armSym) begin
      phase <= PH_W'(1);
      lead  <= 1'b1;
    end else if (lead) begin
      if (phase == PH_W'(HALF - 1)) begin
        phase <= '0;
        lead  <= 1'b0;
      end else begin
        phase <= phase + 1'b1;
      end
    end else if (phase == symLast) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end

  assign inSym   = ~lead;
  assign symEnd  = ~lead && (phase == symLast);
  assign slotOff = phase[SL_W-1:0];
  assign slotIdx = phase[PH_W-1:SL_W];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      pairAcc   <= '0;
      pairCnt   <= '0;
      dataByte  <= '0;
      byteValid <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      if (ctl.clrByte) begin
        pairCnt <= '0;
      end else if (ctl.takePause) begin
        if (modeQuad) begin
          pairAcc <= {slotIdx[1:0], pairAcc[5:2]};
          pairCnt <= pairCnt + 1'b1;
          if (pairCnt == 2'd3) begin
            dataByte  <= {slotIdx[1:0], pairAcc};
            byteValid <= 1'b1;
          end
        end else begin
          dataByte  <= slotIdx;
          byteValid <= 1'b1;
        end
      end
    end

  assign pairBusy = (pairCnt != 2'd0);
endmodule

// File: rtl/ppmCtrl.sv
module ppmCtrl import ppmPkg::*; #(
  parameter  int SLOT_CYC = 256,
  localparam int SL_W     = $clog2(SLOT_CYC),
  localparam int HALF     = SLOT_CYC / 2,
  localparam int TOL      = SLOT_CYC / 16,
  localparam int QUAD_LEN = 4 * SLOT_CYC,
  localparam int WIDE_SOF = 3 * SLOT_CYC,
  localparam int END_GAP  = 3 * HALF,
  localparam int GAP_W    = $clog2(QUAD_LEN) + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pauseEdge,
  input  logic [GAP_W-1:0] gap,
  input  logic [SL_W-1:0]  slotOff,
  input  logic             inSym,
  input  logic             symEnd,
  input  logic             pairBusy,
  output dpCtrlT           ctl,
  output logic             modeQuad,
  output logic             frameStart,
  output logic             frameEnd,
  output logic             frameErr
);
  ppmStateT state, nxt;
  logic gotPause, gotNext, quadNext, doStart, doEnd, doErr;
  logic offGrid;

  function automatic logic near(input logic [GAP_W-1:0] g, input int target);
    return (int'(g) >= target - TOL) && (int'(g) <= target + TOL);
  endfunction

  assign offGrid = (int'(slotOff) < HALF - TOL) || (int'(slotOff) > HALF + TOL);

  always_comb begin
    ctl      = '0;
    nxt      = state;
    gotNext  = gotPause;
    quadNext = modeQuad;
    doStart  = 1'b0;
    doEnd    = 1'b0;
    doErr    = 1'b0;
    unique case (state)
      ST_IDLE: if (pauseEdge) begin
        ctl.clrGap = 1'b1;
        nxt        = ST_SOF;
      end
      ST_SOF: if (pauseEdge) begin
        ctl.clrGap = 1'b1;
        if (near(gap, QUAD_LEN) || near(gap, WIDE_SOF)) begin
          nxt         = ST_DATA;
          ctl.armSym  = 1'b1;
          ctl.clrByte = 1'b1;
          doStart     = 1'b1;
          gotNext     = 1'b0;
          quadNext    = near(gap, QUAD_LEN);
        end
      end else if (int'(gap) > QUAD_LEN + TOL) begin
        nxt = ST_IDLE;
      end
      ST_DATA: if (pauseEdge) begin
        if (near(gap, END_GAP)) begin
          nxt   = ST_IDLE;
          doErr = pairBusy;
          doEnd = ~pairBusy;
        end else if (!inSym || offGrid || gotPause) begin
          nxt   = ST_IDLE;
          doErr = 1'b1;
        end else begin
          ctl.takePause = 1'b1;
          ctl.clrGap    = 1'b1;
          gotNext       = 1'b1;
        end
      end else if (symEnd) begin
        if (!gotPause) begin
          nxt   = ST_IDLE;
          doErr = 1'b1;
        end else begin
          gotNext = 1'b0;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      state      <= ST_IDLE;
      gotPause   <= 1'b0;
      modeQuad   <= 1'b0;
      frameStart <= 1'b0;
      frameEnd   <= 1'b0;
      frameErr   <= 1'b0;
    end else begin
      state      <= nxt;
      gotPause   <= gotNext;
      modeQuad   <= quadNext;
      frameStart <= doStart;
      frameEnd   <= doEnd;
      frameErr   <= doErr;
    end
endmodule

// File: rtl/ppmDownlinkDecoder.sv
module ppmDownlinkDecoder import ppmPkg::*; #(
  parameter  int SLOT_CYC = 256,
  localparam int SL_W     = $clog2(SLOT_CYC),
  localparam int GAP_W    = $clog2(4 * SLOT_CYC) + 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pauseIn,
  output logic [7:0] dataByte,
  output logic       byteValid,
  output logic       frameStart,
  output logic       frameEnd,
  output logic       frameErr,
  output logic       modeQuad
);
  dpCtrlT           ctl;
  logic             pauseEdge, inSym, symEnd, pairBusy;
  logic [GAP_W-1:0] gap;
  logic [SL_W-1:0]  slotOff;

  ppmCtrl #(.SLOT_CYC(SLOT_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .pauseEdge(pauseEdge), .gap(gap),
    .slotOff(slotOff), .inSym(inSym), .symEnd(symEnd), .pairBusy(pairBusy),
    .ctl(ctl), .modeQuad(modeQuad), .frameStart(frameStart),
    .frameEnd(frameEnd), .frameErr(frameErr)
  );

  ppmData #(.SLOT_CYC(SLOT_CYC)) uData (
    .clk(clk), .rstN(rstN), .pauseIn(pauseIn), .modeQuad(modeQuad),
    .ctl(ctl), .pauseEdge(pauseEdge), .gap(gap), .slotOff(slotOff),
    .inSym(inSym), .symEnd(symEnd), .pairBusy(pairBusy),
    .dataByte(dataByte), .byteValid(byteValid)
  );
endmodule

// File: rtl/ppmDecoderChk.sv
module ppmDecoderChk (
  input logic clk,
  input logic rstN,
  input logic byteValid,
  input logic frameStart,
  input logic frameEnd,
  input logic frameErr,
  input logic modeQuad
);
  // R6
  frame_event_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({frameStart, frameEnd, frameErr}));

  // R2
  mode_change_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeQuad) |-> frameStart);

  // R4
  byte_not_at_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> !frameStart);

  // R7
  no_byte_after_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !byteValid);

  // R6
  no_byte_after_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> !byteValid);
endmodule

bind ppmDownlinkDecoder ppmDecoderChk uChk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .frameStart(frameStart),
  .frameEnd(frameEnd), .frameErr(frameErr), .modeQuad(modeQuad)
);

// File: tb/sim_ppmDownlinkDecoder.sv
module sim_ppmDownlinkDecoder;
  localparam int S   = 32;
  localparam int H   = S / 2;
  localparam int TOL = S / 16;
  localparam int L4  = 4 * S;
  localparam int L256 = 256 * S;
  localparam int PW  = 6;
  localparam logic [1:0] K_BYTE = 2'd0, K_START = 2'd1, K_END = 2'd2, K_ERR = 2'd3;

  logic clk = 1'b0, rstN = 1'b0, pauseIn = 1'b0;
  logic [7:0] dataByte;
  logic byteValid, frameStart, frameEnd, frameErr, modeQuad;

  int checks = 0, fails = 0;
  int lastPos = 0, t2 = 0, symIdx = 0;
  bit running = 1'b0, finished = 1'b0;
  logic [9:0] expQ[$];
  string reqQ[$];

  ppmDownlinkDecoder #(.SLOT_CYC(S)) u0 (
    .clk(clk), .rstN(rstN), .pauseIn(pauseIn), .dataByte(dataByte),
    .byteValid(byteValid), .frameStart(frameStart), .frameEnd(frameEnd),
    .frameErr(frameErr), .modeQuad(modeQuad)
  );

  always #5 clk = ~clk;

  task automatic pushExp(input logic [1:0] kind, input logic [7:0] d, input string req);
    expQ.push_back({kind, d});
    reqQ.push_back(req);
  endtask

  task automatic compareEvt(input logic [9:0] got);
    logic [9:0] exp;
    string req;
    checks++;
    if (expQ.size() == 0) begin
      fails++;
      $display("FAIL R11 unexpected event got %h expected none", got);
    end else begin
      exp = expQ.pop_front();
      req = reqQ.pop_front();
      if (got !== exp) begin
        fails++;
        $display("FAIL %s got %h expected %h", req, got, exp);
      end
    end
  endtask

  // monitor: compares each event against the scoreboard queue
  always @(negedge clk) if (running) begin
    if (frameStart) compareEvt({K_START, 7'd0, modeQuad});
    if (byteValid)  compareEvt({K_BYTE, dataByte});
    if (frameEnd)   compareEvt({K_END, 8'd0});
    if (frameErr)   compareEvt({K_ERR, 8'd0});
  end

  task automatic pauseAt(input int pos);
    repeat (pos - lastPos - PW) @(negedge clk);
    pauseIn = 1'b1;
    repeat (PW) @(negedge clk);
    pauseIn = 1'b0;
    lastPos = pos;
  endtask

  task automatic firstPulse();
    repeat (300) @(negedge clk);
    pauseIn = 1'b1;
    repeat (PW) @(negedge clk);
    pauseIn = 1'b0;
    lastPos = 0;
  endtask

  task automatic sofStart(input bit quad, input string req);
    firstPulse();
    pushExp(K_START, {7'd0, quad}, req);
    pauseAt(quad ? L4 : 3 * S);
    t2 = lastPos;
    symIdx = 0;
  endtask

  task automatic sendByte(input logic [7:0] b, input bit quad, input bit jit, input string req);
    pushExp(K_BYTE, b, req);
    if (quad) begin
      for (int n = 0; n < 4; n++) begin
        int k = (b >> (2 * n)) & 3;
        int sh = jit ? ((n % 2) ? -TOL : TOL) : 0;
        pauseAt(t2 + H + symIdx * L4 + k * S + H + sh);
        symIdx++;
      end
    end else begin
      pauseAt(t2 + H + symIdx * L256 + int'(b) * S + H);
      symIdx++;
    end
  endtask

  task automatic sendEnd(input string req);
    pushExp(K_END, 8'd0, req);
    pauseAt(lastPos + 3 * H);
    repeat (20) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired got running expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs low while held in reset
    checks++;
    if ({dataByte, byteValid, frameStart, frameEnd, frameErr, modeQuad} !== 13'd0) begin
      fails++;
      $display("FAIL R1 reset outputs got %h expected 0",
               {dataByte, byteValid, frameStart, frameEnd, frameErr, modeQuad});
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if ({dataByte, byteValid, frameStart, frameEnd, frameErr, modeQuad} !== 13'd0) begin
      fails++;
      $display("FAIL R1 post-reset outputs got %h expected 0",
               {dataByte, byteValid, frameStart, frameEnd, frameErr, modeQuad});
    end
    running = 1'b1;

    // quad-mode frame: pair order and all slot positions (R2, R4, R6)
    sofStart(1'b1, "R2");
    sendByte(8'hE1, 1'b1, 1'b0, "R4");
    sendByte(8'h3C, 1'b1, 1'b0, "R4");
    sendByte(8'hA5, 1'b1, 1'b0, "R4");
    sendEnd("R6");

    // jittered pauses at the edge of the window (R12)
    sofStart(1'b1, "R2");
    sendByte(8'h96, 1'b1, 1'b1, "R12");
    sendByte(8'h4B, 1'b1, 1'b1, "R12");
    sendEnd("R6");

    // wide-mode frame: outermost slots and a mid value (R3, R5)
    sofStart(1'b0, "R3");
    sendByte(8'h00, 1'b0, 1'b0, "R5");
    sendByte(8'hFF, 1'b0, 1'b0, "R5");
    sendByte(8'h7E, 1'b0, 1'b0, "R5");
    sendEnd("R6");

    // missing pause in second symbol (R7)
    sofStart(1'b1, "R2");
    pushExp(K_ERR, 8'd0, "R7");
    pauseAt(t2 + H + S + H);
    repeat (3 * L4) @(negedge clk);

    // two pauses in one symbol (R8)
    sofStart(1'b1, "R2");
    pushExp(K_ERR, 8'd0, "R8");
    pauseAt(t2 + H + H);
    pauseAt(t2 + H + 2 * S + H);
    repeat (50) @(negedge clk);

    // pause outside the tolerance window (R9)
    sofStart(1'b1, "R2");
    pushExp(K_ERR, 8'd0, "R9");
    pauseAt(t2 + H + S + H + TOL + 3);
    repeat (50) @(negedge clk);

    // end pause while two pairs are pending (R10)
    sofStart(1'b1, "R2");
    pauseAt(t2 + H + 2 * S + H);
    pauseAt(t2 + H + L4 + S + H);
    pushExp(K_ERR, 8'd0, "R10");
    pauseAt(lastPos + 3 * H);
    repeat (50) @(negedge clk);

    // bad opening spacing ignored, later pause restarts the pair (R11)
    firstPulse();
    pauseAt(2 * S);
    pushExp(K_START, 8'd0, "R11");
    pauseAt(lastPos + 3 * S);
    t2 = lastPos;
    symIdx = 0;
    sendByte(8'h5A, 1'b0, 1'b0, "R11");
    sendEnd("R6");

    repeat (100) @(negedge clk);
    // R11: every expected event consumed, none left over
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R11 pending events got %0d expected 0", expQ.size());
    end
    running = 1'b0;
    finishRun();
  end
endmodule